// File: doc/BRIEF.md
# Byte-Serial PCM Codec Port

The block is a full-duplex serial port that exchanges 8-bit samples with an external codec. Software writes bytes into an eight-entry transmit FIFO through a data-register write strobe. Reading the same data register pops the oldest received byte from an eight-entry receive FIFO. The serial clock comes from the system clock through a clock-enable counter. While the enable input is high, the port runs byte frames back to back.

A single shift/load register serves both directions. On the serial-clock rising edge that opens a frame, the next transmit byte is loaded into that register. If the transmit FIFO is empty, the register keeps its previous contents and shifts on. A one-period sync pulse marks that first bit, and the MSB is already on the data output while the pulse is high. Output bits change on rising edges. Input bits are sampled on falling edges and shift into the same register, and the eighth sampled bit completes a byte for the receive FIFO.

Both FIFOs report full and empty. A write into a full transmit FIFO is dropped and raises a sticky overflow flag. A received byte that finds the receive FIFO full is dropped and raises a sticky overrun flag. Only reset clears these flags.

Top module: `pcm_byte_port`

## Requirements
- R1: A cycle with `wr_i` high pushes `wdata_i` into the transmit FIFO. `rdata_o` shows the oldest receive FIFO entry, and a cycle with `rd_i` high pops it.
- R2: On the serial-clock rise that opens a frame, the oldest transmit FIFO byte is popped into the shift register, so frames carry the written bytes in write order.
- R3: `sync_o` goes high on the rise that opens a frame and stays high for exactly one serial-clock period. During that period `sdo_o` carries bit 7 of the frame byte.
- R4: `sdo_o` carries the byte MSB first, one bit per serial-clock period, and changes only on serial-clock rises.
- R5: `sdi_i` is sampled on each serial-clock fall, MSB first. After the eighth fall of a frame, the assembled byte is pushed into the receive FIFO.
- R6: When the transmit FIFO is empty at frame start, the frame sends the current shift-register contents. That is the byte received in the previous frame, or 0x00 for the first frame after reset.
- R7: `sclk_o` has a period of DIV system clocks and is high for the first DIV/2 of them. The first rise appears on the first clock edge with `en_i` high, and frames follow one another without gaps while `en_i` stays high.
- R8: `tx_full_o` is high when eight bytes are queued. A write while the FIFO is full is dropped and sets `tx_ovf_o`, which then stays high until reset.
- R9: A received byte that finds the receive FIFO full is dropped and sets `rx_ovr_o`, which then stays high until reset. The stored bytes are unchanged.
- R10: Reset empties both FIFOs, clears the shift register and both sticky flags, and holds `sclk_o`, `sync_o` and `sdo_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run frames while high |
| wr_i | input | 1 | Data-register write strobe |
| wdata_i | input | 8 | Byte to transmit |
| rd_i | input | 1 | Data-register read strobe (pops receive FIFO) |
| rdata_o | output | 8 | Oldest received byte |
| tx_full_o | output | 1 | Transmit FIFO full |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| rx_full_o | output | 1 | Receive FIFO full |
| rx_empty_o | output | 1 | Receive FIFO empty |
| tx_ovf_o | output | 1 | Sticky: write to full transmit FIFO |
| rx_ovr_o | output | 1 | Sticky: receive byte lost to full FIFO |
| sclk_o | output | 1 | Serial clock to codec |
| sync_o | output | 1 | Frame sync, one serial period |
| sdo_o | output | 1 | Serial data to codec |
| sdi_i | input | 1 | Serial data from codec |

## Verification
Write and read strobes take effect on the next clock edge, so the FIFO flags and `rdata_o` are checked at the following falling system-clock edge. Serial outputs are registered on the same system-clock edge that produces the `sclk_o` transition. The bench therefore captures `sdo_o` and `sync_o` just after each `sclk_o` fall, where they have been stable for half a serial period. It drives `sdi_i` just after each `sclk_o` rise, so the sample taken at the fall is settled. A received byte is in the FIFO by the edge that makes the eighth fall, and the bench reads the receive FIFO only after it has dropped `en_i`, before the next rise.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] pcm_byte_t;
endpackage

// File: rtl/pcm_fifo.sv
module pcm_fifo #(
  parameter int DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  pcm_pkg::pcm_byte_t data_i,
  input  logic              pop_i,
  output pcm_pkg::pcm_byte_t data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  pcm_pkg::pcm_byte_t mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;
  assign data_o  = mem_q[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wptr_q] <= data_i;
        wptr_q <= nxt(wptr_q);
      end
      if (pop_ok) rptr_q <= nxt(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic rise_o,
  output logic fall_o,
  output logic sclk_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign rise_o = en_i && (cnt_q == '0);
  assign fall_o = en_i && (cnt_q == CW'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
      if (rise_o)      sclk_o <= 1'b1;
      else if (fall_o) sclk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_shifter.sv
module pcm_shifter (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic              tx_empty_i,
  input  pcm_pkg::pcm_byte_t tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output pcm_pkg::pcm_byte_t rx_data_o,
  output logic              sync_o,
  output logic              sdo_o
);
  localparam int BW = pcm_pkg::BYTE_W;
  localparam int IW = $clog2(BW);
  localparam logic [IW-1:0] LAST = IW'(BW - 1);

  pcm_pkg::pcm_byte_t sr_q;
  logic [IW-1:0] bit_q;
  logic in_q;

  assign tx_pop_o  = rise_i && (bit_q == LAST) && !tx_empty_i;
  assign rx_push_o = fall_i && (bit_q == LAST);
  assign rx_data_o = {sr_q[BW-2:0], sdi_i};
  assign sdo_o     = sr_q[BW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bit_q  <= LAST;
      in_q   <= 1'b0;
      sync_o <= 1'b0;
    end else if (!en_i) begin
      // abandon any partial byte; next enable opens a new frame
      bit_q  <= LAST;
      sync_o <= 1'b0;
    end else begin
      if (fall_i) in_q <= sdi_i;
      if (rise_i) begin
        if (bit_q == LAST) begin
          bit_q  <= '0;
          sync_o <= 1'b1;
          sr_q   <= tx_empty_i ? {sr_q[BW-2:0], in_q} : tx_data_i;
        end else begin
          bit_q  <= bit_q + 1'b1;
          sync_o <= 1'b0;
          sr_q   <= {sr_q[BW-2:0], in_q};
        end
      end
    end
  end
endmodule

// File: rtl/pcm_byte_port.sv
module pcm_byte_port #(
  parameter int DIV   = 8,
  parameter int DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  output logic       tx_full_o,
  output logic       tx_empty_o,
  output logic       rx_full_o,
  output logic       rx_empty_o,
  output logic       tx_ovf_o,
  output logic       rx_ovr_o,
  output logic       sclk_o,
  output logic       sync_o,
  output logic       sdo_o,
  input  logic       sdi_i
);
  logic rise, fall, tx_pop, rx_push, tx_drop, rx_drop;
  pcm_pkg::pcm_byte_t tx_head, rx_byte;

  pcm_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .push_i(wr_i), .data_i(wdata_i), .pop_i(tx_pop),
    .data_o(tx_head), .full_o(tx_full_o), .empty_o(tx_empty_o), .drop_o(tx_drop)
  );

  pcm_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .push_i(rx_push), .data_i(rx_byte), .pop_i(rd_i),
    .data_o(rdata_o), .full_o(rx_full_o), .empty_o(rx_empty_o), .drop_o(rx_drop)
  );

  pcm_clkgen #(.DIV(DIV)) u_clkgen (
    .clk_i, .rst_ni, .en_i, .rise_o(rise), .fall_o(fall), .sclk_o
  );

  pcm_shifter u_shifter (
    .clk_i, .rst_ni, .en_i, .rise_i(rise), .fall_i(fall), .sdi_i,
    .tx_empty_i(tx_empty_o), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_byte), .sync_o, .sdo_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ovf_o <= 1'b0;
      rx_ovr_o <= 1'b0;
    end else begin
      if (tx_drop) tx_ovf_o <= 1'b1;
      if (rx_drop) rx_ovr_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pcm_byte_port_chk.sv
module pcm_byte_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic tx_full_o,
  input logic tx_empty_o,
  input logic rx_full_o,
  input logic rx_empty_o,
  input logic tx_ovf_o,
  input logic rx_ovr_o,
  input logic sclk_o,
  input logic sync_o,
  input logic sdo_o
);
  p_sync_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $rose(sclk_o));
  p_sync_one_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_o) && $past(sync_o)) |-> !sync_o);
  p_sdo_stable_at_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(sdo_o));
  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_o |=> tx_ovf_o);
  p_ovf_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ovf_o) |-> $past(tx_full_o && wr_i));
  p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovr_o |=> rx_ovr_o);
  p_ovr_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovr_o) |-> $past(rx_full_o));
  p_flags_exclusive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full_o && tx_empty_o) && !(rx_full_o && rx_empty_o));
endmodule

bind pcm_byte_port pcm_byte_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i),
  .tx_full_o(tx_full_o), .tx_empty_o(tx_empty_o),
  .rx_full_o(rx_full_o), .rx_empty_o(rx_empty_o),
  .tx_ovf_o(tx_ovf_o), .rx_ovr_o(rx_ovr_o),
  .sclk_o(sclk_o), .sync_o(sync_o), .sdo_o(sdo_o)
);

// File: tb/pcm_byte_port_test.sv
`timescale 1ns/1ps
module pcm_byte_port_test;
  localparam int DIV = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, sdi_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic tx_full_o, tx_empty_o, rx_full_o, rx_empty_o, tx_ovf_o, rx_ovr_o;
  logic sclk_o, sync_o, sdo_o;

  int errors = 0, checks = 0;
  logic [7:0] rx_exp[$];
  logic [7:0] tx_got[$];
  logic [7:0] wq[$];
  int frames = 0, fall_idx = 8;
  logic [7:0] cur = '0, cbyte = '0;
  int cidx = 0;

  always #10 clk_i = ~clk_i;

  pcm_byte_port #(.DIV(DIV), .DEPTH(8)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_tx(input int k, input int n);
    if (k < n) return wq[k];
    if (k == 0) return 8'h00;
    return rx_exp[k-1];
  endfunction

  // codec model: new byte on each frame start, next bit after each rise
  initial forever begin
    @(posedge sclk_o); #1;
    if (sync_o) begin
      cbyte = 8'($urandom);
      cidx = 7;
      rx_exp.push_back(cbyte);
    end
    sdi_i = cbyte[cidx];
    if (cidx > 0) cidx--;
  end

  // serial monitor: capture sync and data after each fall
  initial forever begin
    @(negedge sclk_o); #1;
    if (sync_o) begin
      chk(fall_idx == 8, "R3 sync at byte start", fall_idx, 8);
      fall_idx = 0;
      cur = '0;
    end else if (fall_idx >= 8) begin
      chk(1'b0, "R7 frames back to back", 0, 1);
      fall_idx = 0;
    end
    cur = {cur[6:0], sdo_o};
    fall_idx++;
    if (fall_idx == 8) begin
      tx_got.push_back(cur);
      frames++;
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    en_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rx_exp.delete(); tx_got.delete(); wq.delete();
    fall_idx = 8;
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = b;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic run_frames(input int m, input bit measure);
    int hi, tot;
    frames = 0; fall_idx = 8;
    tx_got.delete(); rx_exp.delete();
    @(negedge clk_i);
    en_i = 1'b1;
    @(posedge clk_i); #1;
    chk(sclk_o && sync_o, "R7 first rise on enable", {sclk_o, sync_o}, 3);
    chk(sdo_o == exp_tx(0, wq.size()) >> 7, "R3 MSB valid with sync", sdo_o, exp_tx(0, wq.size()) >> 7);
    if (measure) begin
      hi = 1;
      while (1) begin @(posedge clk_i); #1; if (!sclk_o) break; hi++; end
      tot = hi;
      while (1) begin @(posedge clk_i); #1; tot++; if (sclk_o) break; end
      chk(hi == DIV / 2, "R7 sclk high time", hi, DIV / 2);
      chk(tot == DIV, "R7 sclk period", tot, DIV);
    end
    wait (frames == m);
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic check_tx(input int m, input string req);
    chk(tx_got.size() == m, req, tx_got.size(), m);
    for (int k = 0; k < m && k < tx_got.size(); k++)
      chk(tx_got[k] == exp_tx(k, wq.size()), req, tx_got[k], exp_tx(k, wq.size()));
  endtask

  task automatic read_all(input int m, input string req);
    for (int k = 0; k < m; k++) begin
      @(negedge clk_i);
      chk(!rx_empty_o && rdata_o == rx_exp[k], req, rdata_o, rx_exp[k]);
      rd_i = 1'b1;
      @(negedge clk_i);
      rd_i = 1'b0;
    end
    @(negedge clk_i);
    chk(rx_empty_o, "R1 rx empty after reads", rx_empty_o, 1);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    do_reset();
    // R10 reset state
    @(negedge clk_i);
    chk({sclk_o, sync_o, sdo_o} == 3'b000, "R10 serial outputs low", {sclk_o, sync_o, sdo_o}, 0);
    chk(tx_empty_o && rx_empty_o && !tx_full_o && !rx_full_o, "R10 fifos empty",
        {tx_empty_o, rx_empty_o, tx_full_o, rx_full_o}, 4'b1100);
    chk(!tx_ovf_o && !rx_ovr_o, "R10 sticky flags clear", {tx_ovf_o, rx_ovr_o}, 0);

    // R9 / R6: no writes, nine frames; stale data, receive overrun
    run_frames(9, 1'b1);
    check_tx(9, "R6 stale shift data");
    chk(rx_full_o && rx_ovr_o, "R9 overrun sticky", {rx_full_o, rx_ovr_o}, 3);
    read_all(8, "R9 stored bytes kept");
    chk(rx_ovr_o, "R9 overrun stays after reads", rx_ovr_o, 1);

    // R8: fill transmit FIFO and overflow it
    do_reset();
    for (int k = 0; k < 9; k++) begin
      logic [7:0] b = 8'($urandom);
      if (k < 8) wq.push_back(b);
      write_byte(b);
      if (k == 7) chk(tx_full_o && !tx_ovf_o, "R8 full at eight", {tx_full_o, tx_ovf_o}, 2);
    end
    chk(tx_ovf_o, "R8 overflow on ninth write", tx_ovf_o, 1);
    run_frames(8, 1'b0);
    check_tx(8, "R8 dropped write not sent");
    chk(tx_empty_o && tx_ovf_o, "R2 tx drained, flag kept", {tx_empty_o, tx_ovf_o}, 3);
    chk(rx_full_o && !rx_ovr_o, "R5 eight received no overrun", {rx_full_o, rx_ovr_o}, 2);
    read_all(8, "R5 received bytes MSB first");

    // random rounds: R1 R2 R4 R5 R6
    for (int r = 0; r < 8; r++) begin
      wq.delete();
      n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) begin
        logic [7:0] b = 8'($urandom);
        wq.push_back(b);
        write_byte(b);
      end
      chk(!tx_empty_o, "R1 write queued", tx_empty_o, 0);
      run_frames(n + 2, 1'b0);
      check_tx(n + 2, "R2 R4 R6 transmit order");
      read_all(n + 2, "R1 R5 receive path");
    end

    // directed: all-ones and alternating bytes
    wq.delete();
    wq.push_back(8'hFF); wq.push_back(8'h01); wq.push_back(8'hA5);
    foreach (wq[k]) write_byte(wq[k]);
    run_frames(4, 1'b1);
    check_tx(4, "R4 directed patterns");
    read_all(4, "R5 directed receive");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule